// File: doc/BRIEF.md
# Two-Wire Register Slave with 16-bit Words

This block is a slave on a two-wire serial control bus (clock line plus open-drain data line). It holds a bank of 16-bit configuration registers that are selected by an 8-bit register pointer. Both bus lines are oversampled by the system clock. The block finds START and STOP conditions and matches the device address. It loads the register pointer from the first byte after a write address. It then moves whole 16-bit words in or out, with the most significant byte first.

A host writes by sending the device write byte, one pointer byte and then pairs of data bytes. A register only changes once both bytes of its word have arrived, and the pointer then moves to the next register. A host reads by first setting the pointer with a short write. It then issues a repeated START and the device read byte, and clocks out bytes for as long as it acknowledges. The data line is only ever pulled low, through an output-enable. A parallel look-up port lets a testbench or neighbouring logic see any register directly.

Top module: `twb_reg_slave`

## Requirements
- R1: After reset the data-line pull-down `sdaOe` is off and every register in the bank reads 0x0000.
- R2: The 7-bit device address is 0x5D with the direction bit as the byte's LSB. The byte 0xBA (write) or 0xBB (read) is acknowledged by asserting `sdaOe` during the ninth clock pulse.
- R3: An address byte that does not match is not acknowledged. Every later byte is then ignored: no acknowledge and no register change until the next START, even if a later byte equals 0xBA.
- R4: In a write, the byte after the address loads the register pointer. The next two bytes form one word, high byte first, and that word is stored at the pointer after the low byte arrives. Every received byte of a matched transfer is acknowledged.
- R5: A word that ends after only its high byte, because of a STOP or a repeated START, leaves the addressed register unchanged.
- R6: The pointer advances by one after each complete 16-bit word, both written and read. It wraps from 0xFF to 0x00.
- R7: After a repeated START and 0xBB, the slave sends the register at the pointer, high byte first, MSB first within each byte. Each bit is held on the line while the clock is high.
- R8: When the host acknowledges a byte, the slave sends the next one: the low byte of the same register, or after a low byte the high byte of the next register. When the host does not acknowledge, the slave stops driving the line.
- R9: `sdaOe` changes only while the clock line is low.
- R10: A STOP releases the data line and returns the slave to idle. A later START begins a fresh address decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | High to pull the data line low |
| dbgAddr | input | 8 | Register index for the parallel look-up port |
| dbgData | output | 16 | Contents of the register selected by `dbgAddr` |

## Verification
The assertions assume a well-behaved host:
- Each low phase of the clock line is longer than the synchronizer latency plus one system clock.
- The host changes the data line only while the clock is low, except when it forms START or STOP.
- The host never issues START or STOP while the slave is pulling the line low.

The bench's bus tasks hold every clock phase for eight system clocks. They move the host's data only in the middle of a low phase. They issue START and STOP only after an acknowledge slot has ended, or after a read byte that the host did not acknowledge.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_RD
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // sample one received bit
    logic setPtr;    // load pointer from received byte
    logic holdHi;    // park received byte as high half
    logic commit;    // store full word and step pointer
    logic loadHi;    // fetch word, present its high byte
    logic loadLo;    // present low byte of fetched word
    logic advance;   // step pointer after a sent word
    logic shiftTx;   // move to next transmit bit
  } dpCtl_t;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] prevLevel;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '1;
          else       chain[g] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '1;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= '1;
    else       prevLevel <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prevLevel;
  assign fall  = ~level & prevLevel;
endmodule

// File: rtl/twb_datapath.sv
module twb_datapath
  import twb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaBit,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] ptr,
  output logic [WORD_W-1:0] dbgData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] bank [DEPTH];
  logic [BYTE_W-1:0] hiByte;
  logic [BYTE_W-1:0] txLo;
  logic [BYTE_W-1:0] txShift;
  logic [ADDR_W-1:0] nextPtr;
  logic [WORD_W-1:0] fetchWord;

  assign nextPtr   = ctl.advance ? ADDR_W'(ptr + 1'b1) : ptr;
  assign fetchWord = bank[nextPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      hiByte  <= '0;
      ptr     <= '0;
      txLo    <= '0;
      txShift <= '0;
    end else begin
      if (ctl.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (ctl.holdHi)  hiByte <= rxByte;
      if (ctl.setPtr)  ptr <= rxByte[ADDR_W-1:0];
      else if (ctl.commit || ctl.advance) ptr <= ADDR_W'(ptr + 1'b1);
      if (ctl.loadHi) begin
        txShift <= fetchWord[WORD_W-1:BYTE_W];
        txLo    <= fetchWord[BYTE_W-1:0];
      end else if (ctl.loadLo) begin
        txShift <= txLo;
      end else if (ctl.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (ctl.commit) begin
      bank[ptr] <= {hiByte, rxByte};
    end
  end

  assign txMsb   = txShift[BYTE_W-1];
  assign dbgData = bank[dbgAddr];
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
  import twb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpCtl_t            ctl,
  output logic              sdaOe,
  output logic              busIdle,
  output logic              ackOe,
  output logic              txEn
);
  busState_t            state, nState, afterAck, nAfterAck;
  logic [BIT_CNT_W-1:0] bitCnt, nBitCnt;
  logic                 ackPhase, nAckPhase;
  logic                 nAckOe, nTxEn;
  logic                 hiHave, nHiHave;
  logic                 loSel, nLoSel;
  logic                 hostAck, nHostAck;

  localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

  always_comb begin
    nState    = state;
    nAfterAck = afterAck;
    nBitCnt   = bitCnt;
    nAckPhase = ackPhase;
    nAckOe    = ackOe;
    nTxEn     = txEn;
    nHiHave   = hiHave;
    nLoSel    = loSel;
    nHostAck  = hostAck;
    ctl       = '0;

    if (startDet || stopDet) begin
      nState    = startDet ? ST_DEV : ST_IDLE;
      nBitCnt   = '0;
      nAckPhase = 1'b0;
      nAckOe    = 1'b0;
      nTxEn     = 1'b0;
      nHiHave   = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV, ST_REG, ST_WR: begin
          if (!ackPhase) begin
            if (sclRise && bitCnt != FULL) begin
              ctl.shiftIn = 1'b1;
              nBitCnt     = bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              nBitCnt   = '0;
              nAckPhase = 1'b1;
              nAckOe    = 1'b1;
              if (state == ST_DEV) begin
                if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                  nAfterAck = rxByte[0] ? ST_RD : ST_REG;
                end else begin
                  nState    = ST_IDLE;
                  nAckPhase = 1'b0;
                  nAckOe    = 1'b0;
                end
              end else if (state == ST_REG) begin
                ctl.setPtr = 1'b1;
                nHiHave    = 1'b0;
                nAfterAck  = ST_WR;
              end else begin
                nAfterAck = ST_WR;
                if (!hiHave) begin
                  ctl.holdHi = 1'b1;
                  nHiHave    = 1'b1;
                end else begin
                  ctl.commit = 1'b1;
                  nHiHave    = 1'b0;
                end
              end
            end
          end else if (sclFall) begin
            nAckPhase = 1'b0;
            nAckOe    = 1'b0;
            nState    = afterAck;
            if (afterAck == ST_RD) begin
              ctl.loadHi = 1'b1;
              nTxEn      = 1'b1;
              nLoSel     = 1'b0;
            end
          end
        end
        ST_RD: begin
          if (!ackPhase) begin
            if (sclRise) begin
              nBitCnt = bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL) begin
              nBitCnt   = '0;
              nTxEn     = 1'b0;
              nAckPhase = 1'b1;
            end else if (sclFall && bitCnt != '0) begin
              ctl.shiftTx = 1'b1;
            end
          end else begin
            if (sclRise) begin
              nHostAck = ~sdaBit;
            end else if (sclFall) begin
              nAckPhase   = 1'b0;
              ctl.advance = loSel;
              if (hostAck) begin
                nTxEn      = 1'b1;
                ctl.loadHi = loSel;
                ctl.loadLo = ~loSel;
                nLoSel     = ~loSel;
              end else begin
                nState = ST_IDLE;
              end
            end
          end
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackOe    <= 1'b0;
      txEn     <= 1'b0;
      hiHave   <= 1'b0;
      loSel    <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      state    <= nState;
      afterAck <= nAfterAck;
      bitCnt   <= nBitCnt;
      ackPhase <= nAckPhase;
      ackOe    <= nAckOe;
      txEn     <= nTxEn;
      hiHave   <= nHiHave;
      loSel    <= nLoSel;
      hostAck  <= nHostAck;
    end
  end

  assign sdaOe   = ackOe | (txEn & ~txMsb);
  assign busIdle = (state == ST_IDLE);
endmodule

// File: rtl/twb_reg_slave.sv
module twb_reg_slave
  import twb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5D,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [WORD_W-1:0] dbgData
);
  logic [1:0]        lineLvl, lineRise, lineFall;
  logic              startDet, stopDet;
  dpCtl_t            dpCtl;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  logic [ADDR_W-1:0] ptr;
  logic              busIdle, ackOe, txEn;

  twb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .rawIn ({sclIn, sdaIn}),
    .level (lineLvl),
    .rise  (lineRise),
    .fall  (lineFall)
  );

  // index 1 is the clock line, index 0 the data line
  assign startDet = lineLvl[1] & lineFall[0];
  assign stopDet  = lineLvl[1] & lineRise[0];

  twb_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (lineRise[1]),
    .sclFall  (lineFall[1]),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaBit   (lineLvl[0]),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .ctl      (dpCtl),
    .sdaOe    (sdaOe),
    .busIdle  (busIdle),
    .ackOe    (ackOe),
    .txEn     (txEn)
  );

  twb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .sdaBit  (lineLvl[0]),
    .dbgAddr (dbgAddr),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .ptr     (ptr),
    .dbgData (dbgData)
  );
endmodule

// File: rtl/twb_reg_slave_chk.sv
module twb_reg_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [ADDR_W-1:0] dbgAddr,
  input logic [15:0]       dbgData,
  input logic              commit,
  input logic [ADDR_W-1:0] ptr,
  input logic              stopDet,
  input logic              busIdle,
  input logic              ackOe,
  input logic              txEn
);
  AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclIn); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !sdaOe); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R10

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(commit) |-> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R6

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (($past(dbgAddr) == dbgAddr) && !$past(commit)) |-> $stable(dbgData)); // R5

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackOe, txEn})); // R2
endmodule

bind twb_reg_slave twb_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .dbgAddr (dbgAddr),
  .dbgData (dbgData),
  .commit  (dpCtl.commit),
  .ptr     (ptr),
  .stopDet (stopDet),
  .busIdle (busIdle),
  .ackOe   (ackOe),
  .txEn    (txEn)
);

// File: tb/twb_reg_slave_tb.sv
module twb_reg_slave_tb;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaLine;
  logic        sdaOe;
  logic [7:0]  dbgAddr = '0;
  logic [15:0] dbgData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int    expQ[$];
  string tagQ[$];
  int    obsQ[$];

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  twb_reg_slave u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclM),
    .sdaIn   (sdaLine),
    .sdaOe   (sdaOe),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares observed bus results against expected items
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0 && expQ.size() > 0) begin
        check(tagQ.pop_front(), obsQ.pop_front(), expQ.pop_front());
      end
    end
  end

  task automatic busStart();
    sdaM = 1'b1; hold(Q);
    sclM = 1'b1; hold(Q);
    sdaM = 1'b0; hold(Q);
    sclM = 1'b0; hold(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold(Q);
    sclM = 1'b1; hold(Q);
    sdaM = 1'b1; hold(Q);
  endtask

  // expAck: 0 means the slave pulls the line low in the ninth pulse
  task automatic sendByte(input logic [7:0] b, input int expAck, input string tag);
    expQ.push_back(expAck);
    tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hold(Q);
      sclM = 1'b1; hold(Q);
      sclM = 1'b0; hold(Q);
    end
    sdaM = 1'b1; hold(Q);
    sclM = 1'b1; hold(Q/2);
    obsQ.push_back(int'(sdaLine));
    hold(Q/2);
    sclM = 1'b0; hold(Q);
  endtask

  task automatic recvByte(input logic [7:0] expByte, input bit hostAck, input string tag);
    logic [7:0] v = '0;
    expQ.push_back(int'(expByte));
    tagQ.push_back(tag);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(Q);
      sclM = 1'b1; hold(Q/2);
      v = {v[6:0], sdaLine};
      hold(Q/2);
      sclM = 1'b0;
    end
    obsQ.push_back(int'(v));
    hold(Q);
    sdaM = ~hostAck; hold(Q);
    sclM = 1'b1; hold(Q);
    sclM = 1'b0; hold(Q);
    sdaM = 1'b1;
  endtask

  task automatic peekReg(input logic [7:0] a, input logic [15:0] exp, input string tag);
    dbgAddr = a;
    hold(2);
    check(tag, int'(dbgData), int'(exp));
  endtask

  task automatic finishRun();
    hold(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    hold(5);
    rstN = 1'b1;
    hold(5);

    // R1: reset state
    check("R1 sdaOe after reset", int'(sdaOe), 0);
    peekReg(8'h09, 16'h0000, "R1 reg 0x09 reset");
    peekReg(8'hFF, 16'h0000, "R1 reg 0xFF reset");

    // R2 R4: single word write 0x0284 to 0x09
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'h09, 0, "R4 pointer byte ack");
    sendByte(8'h02, 0, "R4 high byte ack");
    sendByte(8'h84, 0, "R4 low byte ack");
    busStop();
    check("R10 released after stop", int'(sdaOe), 0);
    peekReg(8'h09, 16'h0284, "R4 reg 0x09 written");

    // R6: burst across the pointer wrap
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'hFE, 0, "R4 pointer byte ack");
    sendByte(8'h11, 0, "R6 data ack");
    sendByte(8'h11, 0, "R6 data ack");
    sendByte(8'h22, 0, "R6 data ack");
    sendByte(8'h22, 0, "R6 data ack");
    sendByte(8'h33, 0, "R6 data ack");
    sendByte(8'h33, 0, "R6 data ack");
    busStop();
    peekReg(8'hFE, 16'h1111, "R6 reg 0xFE");
    peekReg(8'hFF, 16'h2222, "R6 reg 0xFF");
    peekReg(8'h00, 16'h3333, "R6 reg 0x00 after wrap");

    // R5: high byte only, then STOP
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'h20, 0, "R4 pointer byte ack");
    sendByte(8'hAB, 0, "R5 lone high byte ack");
    busStop();
    peekReg(8'h20, 16'h0000, "R5 reg 0x20 unchanged after stop");

    // R5: full word then lone high byte, then repeated START
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'h21, 0, "R4 pointer byte ack");
    sendByte(8'h12, 0, "R4 high byte ack");
    sendByte(8'h34, 0, "R4 low byte ack");
    sendByte(8'h56, 0, "R5 lone high byte ack");
    busStart();
    sendByte(8'hBA, 0, "R10 address after restart ack");
    busStop();
    peekReg(8'h21, 16'h1234, "R4 reg 0x21 written");
    peekReg(8'h22, 16'h0000, "R5 reg 0x22 unchanged after restart");

    // R3: wrong device address, later bytes ignored
    busStart();
    sendByte(8'hB8, 1, "R3 wrong address nack");
    sendByte(8'h09, 1, "R3 ignored byte");
    sendByte(8'hBA, 1, "R3 ignored address-like byte");
    sendByte(8'hFF, 1, "R3 ignored byte");
    sendByte(8'hFF, 1, "R3 ignored byte");
    busStop();
    peekReg(8'h09, 16'h0284, "R3 reg 0x09 untouched");

    // R7 R8: read two words from 0x09
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'h09, 0, "R4 pointer byte ack");
    busStart();
    sendByte(8'hBB, 0, "R2 read address ack");
    recvByte(8'h02, 1'b1, "R7 high byte of 0x09");
    recvByte(8'h84, 1'b1, "R7 low byte of 0x09");
    recvByte(8'h00, 1'b1, "R8 high byte of 0x0A");
    recvByte(8'h00, 1'b0, "R8 low byte of 0x0A");
    check("R8 released after nack", int'(sdaOe), 0);
    busStop();

    // R6 R8: read across the wrap
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'hFF, 0, "R4 pointer byte ack");
    busStart();
    sendByte(8'hBB, 0, "R2 read address ack");
    recvByte(8'h22, 1'b1, "R7 high byte of 0xFF");
    recvByte(8'h22, 1'b1, "R7 low byte of 0xFF");
    recvByte(8'h33, 1'b1, "R6 high byte of 0x00 after wrap");
    recvByte(8'h33, 1'b0, "R6 low byte of 0x00 after wrap");
    check("R8 released after nack", int'(sdaOe), 0);
    busStop();

    // R7: read word with mixed bits from 0x21
    busStart();
    sendByte(8'hBA, 0, "R2 write address ack");
    sendByte(8'h21, 0, "R4 pointer byte ack");
    busStart();
    sendByte(8'hBB, 0, "R2 read address ack");
    recvByte(8'h12, 1'b1, "R7 high byte of 0x21");
    recvByte(8'h34, 1'b0, "R7 low byte of 0x21");
    busStop();
    check("R10 released after stop", int'(sdaOe), 0);

    while (obsQ.size() > 0) hold(1);
    done = 1'b1;
    finishRun();
  end
endmodule